// File: doc/BRIEF.md
# Shared-Cache Staged Power-Down Controller

This controller handles the shared cache of a multi-core package as the package moves into and out of its deepest idle state. It watches one idle flag per core. When every core reports idle, it walks the cache sections from the highest index to the lowest. For each section it asks an external flush engine to write back dirty lines and invalidate clean ones. It switches that section's power off as soon as the engine reports the section is clean. Only one section is ever being flushed, so the work is spread out instead of happening in one long pass.

When the last section is gated, the package is in its deep idle state with the whole cache dark. A core that wakes starts the restore. Sections come back one at a time in ascending order. Each one waits a fixed settle time before the controller marks it usable and moves to the next. If a core wakes partway through a flush, the controller finishes the section in hand and stops there. The gated upper sections are then restored in the same staged way, and the lower sections stay in service throughout.

A lookup gate sits next to the cache tag path. It turns every access to a section that is gated, being flushed or still settling into a miss, and it blocks allocation into such a section.

Top module: `scg_ctrl`

## Requirements
- R1: After reset, `pkg_state` is ACTIVE (code 0), every bit of `sec_pwr_en` and `sec_usable` is 1, and `flush_req` is all zero.
- R2: While ACTIVE, the controller stays ACTIVE and raises no flush request unless all cores are idle. When all cores are idle at a clock edge, `pkg_state` becomes FLUSHING (code 1) at that edge, and the request for section N-1 rises one edge later.
- R3: Sections are flushed one at a time in descending order, from N-1 down to 0. At most one bit of `flush_req` is ever set.
- R4: A section's power enable falls exactly at the edge that samples its own `flush_done` bit while its request is high. A `flush_done` bit for a section that is not being requested has no effect.
- R5: At the edge that gates section 0, `pkg_state` becomes DEEP_IDLE (code 2), and all power enables are 0 while in that state.
- R6: In DEEP_IDLE, a clear idle flag on any core moves `pkg_state` to RESTORING (code 3) at the next edge. Section 0 is powered one edge after that. Sections power up one at a time in ascending order, and each enable rises SETTLE+1 cycles after the previous one.
- R7: A section becomes usable exactly SETTLE cycles after its power enable rises. When the top section becomes usable, `pkg_state` returns to ACTIVE.
- R8: `lk_hit` = `lk_valid` AND `lk_tag_hit` AND the addressed section is usable. `lk_alloc_ok` = `lk_valid` AND the addressed section is usable. A section is not usable while it is gated, while it is being flushed (from the edge its flush starts) or while it is settling.
- R9: If any core is awake when the current section's `flush_done` is sampled, the controller gates that section and issues no further flush request. It enters RESTORING at that edge and restores from the just-gated section upward. Sections below it stay powered and usable the whole time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_idle | input | NUM_CORES | Per-core deep idle flag |
| flush_req | output | NUM_SECTIONS | One-hot request to flush a section |
| flush_done | input | NUM_SECTIONS | One-cycle pulse: that section is clean |
| sec_pwr_en | output | NUM_SECTIONS | Per-section power enable |
| sec_usable | output | NUM_SECTIONS | Section may be hit and allocated into |
| lk_valid | input | 1 | Cache lookup in progress |
| lk_sec | input | SW | Section addressed by the lookup |
| lk_tag_hit | input | 1 | Tag match from the array |
| lk_hit | output | 1 | Gated hit result |
| lk_alloc_ok | output | 1 | Allocation into the addressed section allowed |
| pkg_state | output | 2 | 0 ACTIVE, 1 FLUSHING, 2 DEEP_IDLE, 3 RESTORING |

## Verification
An input changed on a falling edge is seen in `pkg_state` one cycle later. A section's power enable drops one cycle after its `flush_done` pulse is driven. After wake, section 0 powers two cycles after the wake, each later section SETTLE+1 cycles after the one before, and usability comes SETTLE cycles after each enable. The bench logs the falling-edge cycle of every output change and compares those logs to the expected offsets. The lookup outputs are combinational, so they are checked shortly after the inputs are driven, within the same cycle.

// File: rtl/scg_pkg.sv
package scg_pkg;

    typedef enum logic [1:0] {
        PKG_ACTIVE    = 2'd0,
        PKG_FLUSHING  = 2'd1,
        PKG_DEEP_IDLE = 2'd2,
        PKG_RESTORING = 2'd3
    } pkg_state_e;

    // One command per cycle, applied to the section at the sequencer cursor.
    typedef struct packed {
        logic gate;
        logic power_up;
        logic set_ready;
        logic clr_ready;
    } sec_cmd_t;

    localparam sec_cmd_t CMD_NONE = '0;

endpackage

// File: rtl/scg_core_watch.sv
module scg_core_watch #(
    parameter int NUM_CORES = 4
) (
    input  logic [NUM_CORES-1:0] core_idle,
    output logic                 all_idle
);
    assign all_idle = &core_idle;
endmodule

// File: rtl/scg_settle_timer.sv
module scg_settle_timer #(
    parameter int SETTLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic expired
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic          running;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (running) begin
            if (cnt == LAST) running <= 1'b0;
            else             cnt     <= cnt + CW'(1);
        end
    end

    assign expired = running && (cnt == LAST);

    assert_timer_bound_R7: assert property (@(posedge clk) disable iff (rst)
        running |-> (cnt <= LAST));
endmodule

// File: rtl/scg_sequencer.sv
module scg_sequencer
    import scg_pkg::*;
#(
    parameter int NUM_SECTIONS = 8,
    localparam int SW = $clog2(NUM_SECTIONS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    all_idle,
    input  logic [NUM_SECTIONS-1:0] flush_done,
    input  logic                    settled,
    output pkg_state_e              state,
    output logic [SW-1:0]           cur,
    output sec_cmd_t                cmd,
    output logic                    timer_start,
    output logic [NUM_SECTIONS-1:0] flush_req
);
    localparam logic [SW-1:0] TOP = SW'(NUM_SECTIONS - 1);

    // phase 0: prepare the cursor section, phase 1: work on it
    logic phase;
    logic done_hit;

    assign done_hit = (state == PKG_FLUSHING) && phase && flush_done[cur];

    always_comb begin
        cmd         = CMD_NONE;
        timer_start = 1'b0;
        for (int i = 0; i < NUM_SECTIONS; i++) begin
            flush_req[i] = (state == PKG_FLUSHING) && phase && (cur == SW'(i));
        end
        case (state)
            PKG_FLUSHING: begin
                if (!phase)        cmd.clr_ready = 1'b1;
                else if (done_hit) cmd.gate      = 1'b1;
            end
            PKG_RESTORING: begin
                if (!phase) begin
                    cmd.power_up = 1'b1;
                    timer_start  = 1'b1;
                end else if (settled) begin
                    cmd.set_ready = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PKG_ACTIVE;
            cur   <= TOP;
            phase <= 1'b0;
        end else begin
            case (state)
                PKG_ACTIVE: begin
                    if (all_idle) begin
                        state <= PKG_FLUSHING;
                        cur   <= TOP;
                        phase <= 1'b0;
                    end
                end
                PKG_FLUSHING: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else if (done_hit) begin
                        phase <= 1'b0;
                        if (cur == '0)     state <= PKG_DEEP_IDLE;
                        else if (!all_idle) state <= PKG_RESTORING;
                        else               cur   <= cur - SW'(1);
                    end
                end
                PKG_DEEP_IDLE: begin
                    if (!all_idle) begin
                        state <= PKG_RESTORING;
                        cur   <= '0;
                        phase <= 1'b0;
                    end
                end
                PKG_RESTORING: begin
                    if (!phase) begin
                        phase <= 1'b1;
                    end else if (settled) begin
                        phase <= 1'b0;
                        if (cur == TOP) state <= PKG_ACTIVE;
                        else            cur   <= cur + SW'(1);
                    end
                end
                default: state <= PKG_ACTIVE;
            endcase
        end
    end

    assert_req_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flush_req));

    assert_req_in_flush_R3: assert property (@(posedge clk) disable iff (rst)
        (flush_req != '0) |-> (state == PKG_FLUSHING));
endmodule

// File: rtl/scg_section_mask.sv
module scg_section_mask
    import scg_pkg::*;
#(
    parameter int NUM_SECTIONS = 8,
    localparam int SW = $clog2(NUM_SECTIONS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sec_cmd_t                cmd,
    input  logic [SW-1:0]           idx,
    output logic [NUM_SECTIONS-1:0] pwr_en,
    output logic [NUM_SECTIONS-1:0] ready
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_en <= '1;
            ready  <= '1;
        end else begin
            if (cmd.gate)      pwr_en[idx] <= 1'b0;
            if (cmd.power_up)  pwr_en[idx] <= 1'b1;
            if (cmd.set_ready) ready[idx]  <= 1'b1;
            if (cmd.clr_ready) ready[idx]  <= 1'b0;
        end
    end

    assert_usable_powered_R8: assert property (@(posedge clk) disable iff (rst)
        (ready & ~pwr_en) == '0);

    assert_single_transit_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(pwr_en & ~ready) <= 1);
endmodule

// File: rtl/scg_lookup_gate.sv
module scg_lookup_gate #(
    parameter int NUM_SECTIONS = 8,
    localparam int SW = $clog2(NUM_SECTIONS)
) (
    input  logic [NUM_SECTIONS-1:0] usable,
    input  logic                    lk_valid,
    input  logic [SW-1:0]           lk_sec,
    input  logic                    lk_tag_hit,
    output logic                    lk_hit,
    output logic                    lk_alloc_ok
);
    logic sel_ok;

    always_comb begin
        sel_ok = 1'b0;
        for (int i = 0; i < NUM_SECTIONS; i++) begin
            if (lk_sec == SW'(i)) sel_ok = usable[i];
        end
    end

    assign lk_hit      = lk_valid && lk_tag_hit && sel_ok;
    assign lk_alloc_ok = lk_valid && sel_ok;
endmodule

// File: rtl/scg_ctrl.sv
module scg_ctrl
    import scg_pkg::*;
#(
    parameter int NUM_CORES     = 4,
    parameter int NUM_SECTIONS  = 8,
    parameter int SETTLE_CYCLES = 4,
    localparam int SW = $clog2(NUM_SECTIONS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_CORES-1:0]    core_idle,
    output logic [NUM_SECTIONS-1:0] flush_req,
    input  logic [NUM_SECTIONS-1:0] flush_done,
    output logic [NUM_SECTIONS-1:0] sec_pwr_en,
    output logic [NUM_SECTIONS-1:0] sec_usable,
    input  logic                    lk_valid,
    input  logic [SW-1:0]           lk_sec,
    input  logic                    lk_tag_hit,
    output logic                    lk_hit,
    output logic                    lk_alloc_ok,
    output logic [1:0]              pkg_state
);
    logic          all_idle;
    logic          settled;
    logic          timer_start;
    pkg_state_e    state;
    logic [SW-1:0] cur;
    sec_cmd_t      cmd;

    scg_core_watch #(.NUM_CORES(NUM_CORES)) u_watch (
        .core_idle (core_idle),
        .all_idle  (all_idle)
    );

    scg_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (timer_start),
        .expired (settled)
    );

    scg_sequencer #(.NUM_SECTIONS(NUM_SECTIONS)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .all_idle    (all_idle),
        .flush_done  (flush_done),
        .settled     (settled),
        .state       (state),
        .cur         (cur),
        .cmd         (cmd),
        .timer_start (timer_start),
        .flush_req   (flush_req)
    );

    scg_section_mask #(.NUM_SECTIONS(NUM_SECTIONS)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .idx    (cur),
        .pwr_en (sec_pwr_en),
        .ready  (sec_usable)
    );

    scg_lookup_gate #(.NUM_SECTIONS(NUM_SECTIONS)) u_lookup (
        .usable      (sec_usable),
        .lk_valid    (lk_valid),
        .lk_sec      (lk_sec),
        .lk_tag_hit  (lk_tag_hit),
        .lk_hit      (lk_hit),
        .lk_alloc_ok (lk_alloc_ok)
    );

    assign pkg_state = state;

    generate
        for (genvar g = 0; g < NUM_SECTIONS; g++) begin : g_gate_chk
            assert_gate_after_done_R4: assert property (@(posedge clk) disable iff (rst)
                $fell(sec_pwr_en[g]) |-> $past(flush_req[g] && flush_done[g]));
        end
    endgenerate

    assert_deep_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (state == PKG_DEEP_IDLE) |-> (sec_pwr_en == '0));

    assert_flush_entry_R2: assert property (@(posedge clk) disable iff (rst)
        (state == PKG_FLUSHING && $past(state == PKG_ACTIVE)) |-> $past(all_idle));
endmodule

// File: tb/scg_ctrl_bench.sv
module scg_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC  = 4;
    localparam int N   = 8;
    localparam int ST  = 4;
    localparam int LAT = 3;
    localparam int SW  = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NC-1:0] core_idle = '0;
    logic [N-1:0]  flush_req;
    logic [N-1:0]  flush_done = '0;
    logic [N-1:0]  sec_pwr_en;
    logic [N-1:0]  sec_usable;
    logic          lk_valid = 1'b0;
    logic [SW-1:0] lk_sec = '0;
    logic          lk_tag_hit = 1'b0;
    logic          lk_hit;
    logic          lk_alloc_ok;
    logic [1:0]    pkg_state;

    scg_ctrl #(.NUM_CORES(NC), .NUM_SECTIONS(N), .SETTLE_CYCLES(ST)) u_scg_ctrl (
        .clk(clk), .rst(rst), .core_idle(core_idle), .flush_req(flush_req),
        .flush_done(flush_done), .sec_pwr_en(sec_pwr_en), .sec_usable(sec_usable),
        .lk_valid(lk_valid), .lk_sec(lk_sec), .lk_tag_hit(lk_tag_hit),
        .lk_hit(lk_hit), .lk_alloc_ok(lk_alloc_ok), .pkg_state(pkg_state)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rise_cyc[N], fall_cyc[N], rdy_rise[N], rdy_fall[N], done_cyc[N];
    int req_seq[16];
    int req_n = 0;
    int multi_req = 0;
    int eng_cnt = 0;
    bit eng_pulse = 0;
    bit spur = 0;
    bit finished = 0;
    logic [N-1:0] prev_pwr = '1, prev_rdy = '1, prev_req = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        for (int i = 0; i < N; i++) begin
            rise_cyc[i] = -1; fall_cyc[i] = -1; rdy_rise[i] = -1;
            rdy_fall[i] = -1; done_cyc[i] = -1;
        end
        req_n = 0;
        multi_req = 0;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_state(input int code, input int limit);
        for (int k = 0; k < limit && pkg_state != 2'(code); k++) step();
    endtask

    task automatic look(input int sec, input bit tag, input bit eh, input bit ea, input string req);
        lk_valid = 1'b1; lk_sec = SW'(sec); lk_tag_hit = tag;
        #1;
        chk(lk_hit == eh, req, lk_hit, eh);
        chk(lk_alloc_ok == ea, req, lk_alloc_ok, ea);
        lk_valid = 1'b0;
    endtask

    // Monitor and flush-engine model, one process for a fixed ordering
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if ($countones(flush_req) > 1) multi_req++;
            for (int i = 0; i < N; i++) begin
                if (sec_pwr_en[i] && !prev_pwr[i]) rise_cyc[i] = cyc;
                if (!sec_pwr_en[i] && prev_pwr[i]) fall_cyc[i] = cyc;
                if (sec_usable[i] && !prev_rdy[i]) rdy_rise[i] = cyc;
                if (!sec_usable[i] && prev_rdy[i]) rdy_fall[i] = cyc;
                if (flush_req[i] && !prev_req[i]) begin
                    if (req_n < 16) req_seq[req_n] = i;
                    req_n++;
                end
            end
            prev_pwr = sec_pwr_en; prev_rdy = sec_usable; prev_req = flush_req;
            if (eng_pulse) begin
                flush_done = '0; eng_pulse = 0;
            end else if (spur) begin
                flush_done = '1; eng_pulse = 1; spur = 0;
            end else if (flush_req != '0) begin
                eng_cnt++;
                if (eng_cnt >= LAT) begin
                    flush_done = flush_req; eng_pulse = 1; eng_cnt = 0;
                    for (int i = 0; i < N; i++) if (flush_req[i]) done_cyc[i] = cyc;
                end
            end else begin
                eng_cnt = 0;
            end
        end
    end

    task automatic t_reset();
        chk(pkg_state == 2'd0, "R1 state", pkg_state, 0);
        chk(sec_pwr_en == '1, "R1 power", sec_pwr_en, 255);
        chk(sec_usable == '1, "R1 usable", sec_usable, 255);
        chk(flush_req == '0, "R1 req", flush_req, 0);
    endtask

    task automatic t_partial_idle();
        clear_logs();
        step(); core_idle = 4'b0111;
        repeat (20) step();
        chk(pkg_state == 2'd0, "R2 partial idle state", pkg_state, 0);
        chk(req_n == 0, "R2 no request", req_n, 0);
    endtask

    task automatic t_spurious_done();
        clear_logs();
        step(); spur = 1;
        repeat (3) step();
        chk(sec_pwr_en == '1, "R4 stray done ignored", sec_pwr_en, 255);
        chk(pkg_state == 2'd0, "R4 stray done state", pkg_state, 0);
    endtask

    task automatic t_full_flush();
        int c0;
        bit order_ok = 1, gate_ok = 1;
        clear_logs();
        step(); core_idle = '1; c0 = cyc;
        step();
        chk(pkg_state == 2'd1 && cyc == c0 + 1, "R2 enter flushing", pkg_state, 1);
        step();
        chk(flush_req == N'(1 << (N-1)), "R2 first request top", flush_req, 1 << (N-1));
        chk(sec_usable[N-1] == 1'b0, "R8 flushing section unusable", sec_usable[N-1], 0);
        look(N-1, 1, 0, 0, "R8 lookup flushing section");
        look(0, 1, 1, 1, "R8 lookup live section");
        wait_state(2, 400);
        chk(pkg_state == 2'd2, "R5 deep reached", pkg_state, 2);
        chk(cyc == done_cyc[0] + 1, "R5 deep timing", cyc, done_cyc[0] + 1);
        chk(sec_pwr_en == '0, "R5 all dark", sec_pwr_en, 0);
        chk(req_n == N, "R3 request count", req_n, N);
        for (int i = 0; i < N; i++) begin
            if (req_seq[i] != N-1-i) order_ok = 0;
            if (fall_cyc[i] != done_cyc[i] + 1) gate_ok = 0;
        end
        chk(order_ok, "R3 descending order", order_ok, 1);
        chk(multi_req == 0, "R3 single request", multi_req, 0);
        chk(gate_ok, "R4 gate at done edge", gate_ok, 1);
        look(5, 1, 0, 0, "R8 lookup gated section");
        repeat (5) step();
        chk(pkg_state == 2'd2, "R5 deep holds", pkg_state, 2);
    endtask

    task automatic t_wake_restore();
        int cw;
        bit gap_ok = 1, rdy_ok = 1;
        clear_logs();
        step(); core_idle[2] = 1'b0; cw = cyc;
        step();
        chk(pkg_state == 2'd3, "R6 enter restoring", pkg_state, 3);
        step();
        chk(rise_cyc[0] == cw + 2, "R6 section 0 first", rise_cyc[0], cw + 2);
        look(0, 1, 0, 0, "R8 lookup settling section");
        wait_state(0, 400);
        chk(pkg_state == 2'd0, "R7 back to active", pkg_state, 0);
        chk(sec_usable == '1 && sec_pwr_en == '1, "R7 all usable", sec_usable, 255);
        for (int i = 0; i < N; i++) begin
            if (rdy_rise[i] != rise_cyc[i] + ST) rdy_ok = 0;
            if (i > 0 && rise_cyc[i] != rise_cyc[i-1] + ST + 1) gap_ok = 0;
        end
        chk(gap_ok, "R6 ascending staged power", gap_ok, 1);
        chk(rdy_ok, "R7 settle time", rdy_ok, 1);
        look(5, 1, 1, 1, "R8 lookup restored hit");
        look(5, 0, 0, 1, "R8 lookup tag miss");
    endtask

    task automatic t_abort();
        bit low_ok = 1;
        clear_logs();
        step(); core_idle = '1;
        for (int k = 0; k < 200 && req_n < 2; k++) step();
        core_idle[0] = 1'b0;
        wait_state(3, 200);
        chk(pkg_state == 2'd3, "R9 abort to restoring", pkg_state, 3);
        chk(cyc == done_cyc[N-2] + 1, "R9 stop at boundary", cyc, done_cyc[N-2] + 1);
        chk(sec_pwr_en[N-1:N-2] == 2'b00, "R9 upper gated", sec_pwr_en[N-1:N-2], 0);
        wait_state(0, 200);
        chk(req_n == 2, "R9 no further requests", req_n, 2);
        for (int i = 0; i < N-2; i++) if (rdy_fall[i] != -1 || fall_cyc[i] != -1) low_ok = 0;
        chk(low_ok, "R9 lower sections untouched", low_ok, 1);
        chk(rise_cyc[N-1] == rise_cyc[N-2] + ST + 1, "R9 restore upward", rise_cyc[N-1] - rise_cyc[N-2], ST + 1);
        chk(sec_usable == '1, "R9 all usable after", sec_usable, 255);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        step();
        t_reset();
        t_partial_idle();
        t_spurious_done();
        t_full_flush();
        t_wake_restore();
        t_abort();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end
endmodule